// File: doc/BRIEF.md
# Permutation-Driven Set Replacement Engine

This block holds the replacement state of a single cache set with `WAYS` ways. It keeps the state as an explicit total order of way indices, from position 0 (first) to position `WAYS-1` (last). Every policy it offers is described the same way. There is one reordering for a hit at each position, plus one reordering for a miss. The way in the last position is always the one to evict. A cache controller presents at most one access per cycle. On a miss it reads the victim way in the same cycle, and the reordering takes effect at the next rising clock edge.

`WAYS` must be a power of two and at least 2. The order is exported as a flat vector: position `p` occupies bits `[p*IDX_W +: IDX_W]`, where `IDX_W = log2(WAYS)`. A two-bit mode input selects the hit reordering on each access. The mode can change between accesses, and the stored order carries over unchanged.

The engine classifies each cycle into one of three access operations. `OP_IDLE` holds the order. `OP_HIT` applies the hit reordering of the current mode at the hit way's position. `OP_MISS` applies the miss rotation. The only state-register transitions are "hold" (from `OP_IDLE`) and "load next order" (from `OP_HIT` and `OP_MISS`), plus the asynchronous return to the identity order on reset.

Top module: `repl_perm_engine`

## Requirements
- R1: While reset is low, and right after it rises, position p holds way p, so the reported victim is way WAYS-1.
- R2: When `acc_valid` is 0 the order is unchanged at the next edge, whatever `acc_hit`, `acc_way` and `acc_mode` carry.
- R3: `victim_way` always equals the way at position WAYS-1. A valid miss, in any mode, makes the next order [old victim, old pos 0, old pos 1, ..., old pos WAYS-2].
- R4: In recency mode (`acc_mode` = 0), a hit on the way at position h moves it to position 0. Positions 0..h-1 each move down by one, and positions above h keep their ways.
- R5: In fill-order mode (`acc_mode` = 1), a valid hit leaves the order unchanged.
- R6: In tree mode (`acc_mode` = 2), bit 0 of a position picks the top-level half, with 0 meaning the recently used side, and higher bits pick deeper levels. A hit at position h moves the way at position q to q XOR (h AND m). Here m has ones from bit 0 up to and including the lowest bit in which q and h differ, and is all ones when q = h.
- R7: `acc_mode` = 3 behaves exactly like recency mode.
- R8: In every mode, a way at position j is evicted by exactly WAYS-j consecutive misses, and WAYS-j-1 misses leave it in the set.
- R9: The order always holds every way index exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = miss |
| acc_way | input | IDX_W | Way that hit (ignored on a miss) |
| acc_mode | input | 2 | 0 recency, 1 fill order, 2 tree, 3 recency |
| victim_way | output | IDX_W | Way at the last position; the way to refill on a miss |
| order_flat | output | WAYS*IDX_W | Current order, position p at bits [p*IDX_W +: IDX_W] |

## Verification
A wrong internal order is never hidden: the whole order is visible on `order_flat` at the next edge after the access that corrupted it, and `victim_way` reflects the last position combinationally. A wrong hit permutation that only disturbs deep positions shows up on the order port one cycle later. It then reaches `victim_way` only after enough misses push the misplaced way to the end, which is why eviction distances are measured from every starting position. A lost or duplicated way breaks the permutation property at once and is compared against an independent behavioural model after every access.

// File: rtl/repl_pkg.sv
package repl_pkg;

    typedef enum logic [1:0] {
        MODE_RECENCY   = 2'd0,
        MODE_FILL      = 2'd1,
        MODE_TREE      = 2'd2,
        MODE_RECENCY_B = 2'd3
    } repl_mode_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_MISS = 2'd2
    } repl_op_e;

endpackage

// File: rtl/repl_locate.sv
// Finds the position in the order that holds a given way.
module repl_locate #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  logic [WAYS*IDX_W-1:0] order_in,
    input  logic [IDX_W-1:0]      way_in,
    output logic [IDX_W-1:0]      pos_out
);

    logic [WAYS-1:0] match;

    for (genvar p = 0; p < WAYS; p++) begin : g_cmp
        assign match[p] = (order_in[p*IDX_W +: IDX_W] == way_in);
    end

    always_comb begin
        pos_out = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (match[p]) pos_out = IDX_W'(p);
        end
    end

endmodule

// File: rtl/repl_permute.sv
// Computes the next order for one access from the current order.
module repl_permute
    import repl_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  repl_op_e              op,
    input  repl_mode_e            mode,
    input  logic [IDX_W-1:0]      hit_pos,
    input  logic [WAYS*IDX_W-1:0] order_cur,
    output logic [WAYS*IDX_W-1:0] order_next
);

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(WAYS - 1);

    logic [IDX_W-1:0]      shift_pos;
    logic [WAYS*IDX_W-1:0] shift_order;
    logic [WAYS*IDX_W-1:0] tree_order;

    // A miss is the recency move from the last position.
    assign shift_pos = (op == OP_MISS) ? LAST_POS : hit_pos;

    for (genvar p = 0; p < WAYS; p++) begin : g_shift
        localparam logic [IDX_W-1:0] PV = IDX_W'(p);
        if (p == 0) begin : g_head
            assign shift_order[0 +: IDX_W] = order_cur[shift_pos*IDX_W +: IDX_W];
        end else begin : g_body
            assign shift_order[p*IDX_W +: IDX_W] = (PV <= shift_pos)
                ? order_cur[(p-1)*IDX_W +: IDX_W]
                : order_cur[p*IDX_W +: IDX_W];
        end
    end

    // Tree reordering, written in closed form over position bits.
    always_comb begin
        logic [IDX_W-1:0] diff;
        logic [IDX_W-1:0] mask;
        logic [IDX_W-1:0] dest;
        tree_order = '0;
        for (int q = 0; q < WAYS; q++) begin
            diff = IDX_W'(q) ^ hit_pos;
            mask = '1;
            for (int b = IDX_W - 1; b >= 0; b--) begin
                if (diff[b]) mask = {IDX_W{1'b1}} >> (IDX_W - 1 - b);
            end
            dest = IDX_W'(q) ^ (hit_pos & mask);
            tree_order[dest*IDX_W +: IDX_W] = order_cur[q*IDX_W +: IDX_W];
        end
    end

    always_comb begin
        unique case (op)
            OP_IDLE: order_next = order_cur;
            OP_MISS: order_next = shift_order;
            OP_HIT: begin
                unique case (mode)
                    MODE_RECENCY, MODE_RECENCY_B: order_next = shift_order;
                    MODE_FILL:                    order_next = order_cur;
                    MODE_TREE:                    order_next = tree_order;
                    default:                      order_next = order_cur;
                endcase
            end
            default: order_next = order_cur;
        endcase
    end

endmodule

// File: rtl/repl_order_reg.sv
// Holds the order; resets to the identity order.
module repl_order_reg #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [WAYS*IDX_W-1:0] order_d,
    output logic [WAYS*IDX_W-1:0] order_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < WAYS; p++) begin
                order_q[p*IDX_W +: IDX_W] <= IDX_W'(p);
            end
        end else if (load) begin
            order_q <= order_d;
        end
    end

endmodule

// File: rtl/repl_perm_engine.sv
module repl_perm_engine
    import repl_pkg::*;
#(
    parameter int  WAYS  = 4,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_hit,
    input  logic [IDX_W-1:0]      acc_way,
    input  logic [1:0]            acc_mode,
    output logic [IDX_W-1:0]      victim_way,
    output logic [WAYS*IDX_W-1:0] order_flat
);

    repl_op_e              op;
    repl_mode_e            mode;
    logic [IDX_W-1:0]      hit_pos;
    logic [WAYS*IDX_W-1:0] order_q;
    logic [WAYS*IDX_W-1:0] order_d;
    logic [WAYS-1:0]       present;

    assign mode = repl_mode_e'(acc_mode);

    // Access classification.
    always_comb begin
        unique casez ({acc_valid, acc_hit})
            2'b0?:   op = OP_IDLE;
            2'b11:   op = OP_HIT;
            2'b10:   op = OP_MISS;
            default: op = OP_IDLE;
        endcase
    end

    repl_locate #(.WAYS(WAYS), .IDX_W(IDX_W)) u_locate (
        .order_in (order_q),
        .way_in   (acc_way),
        .pos_out  (hit_pos)
    );

    repl_permute #(.WAYS(WAYS), .IDX_W(IDX_W)) u_permute (
        .op         (op),
        .mode       (mode),
        .hit_pos    (hit_pos),
        .order_cur  (order_q),
        .order_next (order_d)
    );

    repl_order_reg #(.WAYS(WAYS), .IDX_W(IDX_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op != OP_IDLE),
        .order_d (order_d),
        .order_q (order_q)
    );

    // Outputs.
    always_comb begin
        victim_way = order_q[(WAYS-1)*IDX_W +: IDX_W];
        order_flat = order_q;
    end

    always_comb begin
        present = '0;
        for (int p = 0; p < WAYS; p++) begin
            present[order_q[p*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    // R9
    perm_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &present);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(order_flat));

    // R3
    miss_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=> (order_flat[IDX_W-1:0] == $past(victim_way)));

    // R3
    miss_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=>
        (order_flat[WAYS*IDX_W-1:IDX_W] == $past(order_flat[(WAYS-1)*IDX_W-1:0])));

    // R5
    fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && acc_mode == 2'd1) |=> $stable(order_flat));

    // R4 R6 R7
    hit_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && acc_mode != 2'd1) |=>
        (order_flat[IDX_W-1:0] == $past(acc_way)));

endmodule

// File: tb/sim_repl_perm_engine.sv
`timescale 1ns/1ps
module sim_repl_perm_engine;

    localparam int WAYS = 4;
    localparam int IW   = $clog2(WAYS);
    localparam int HALF = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               acc_valid = 1'b0;
    logic               acc_hit = 1'b0;
    logic [IW-1:0]      acc_way = '0;
    logic [1:0]         acc_mode = '0;
    logic [IW-1:0]      victim_way;
    logic [WAYS*IW-1:0] order_flat;

    int n_checks = 0;
    int n_fails  = 0;
    int mdl [WAYS];

    always #HALF clk = ~clk;

    repl_perm_engine #(.WAYS(WAYS)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .acc_mode(acc_mode),
        .victim_way(victim_way), .order_flat(order_flat)
    );

    function automatic int dut_pos(int p);
        return int'(order_flat[p*IW +: IW]);
    endfunction

    function automatic logic [WAYS*IW-1:0] mdl_flat();
        logic [WAYS*IW-1:0] v;
        for (int p = 0; p < WAYS; p++) v[p*IW +: IW] = IW'(mdl[p]);
        return v;
    endfunction

    task automatic check_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_order(input string tag);
        n_checks++;
        if (order_flat !== mdl_flat()) begin
            n_fails++;
            $display("FAIL %s order actual %h expected %h", tag, order_flat, mdl_flat());
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < WAYS; p++) mdl[p] = p;
    endtask

    task automatic model_apply(input bit v, input bit h, input int w, input int m);
        int nxt [WAYS];
        int hp;
        int np;
        int lowm;
        if (!v) return;
        hp = 0;
        for (int p = 0; p < WAYS; p++) if (mdl[p] == w) hp = p;
        for (int p = 0; p < WAYS; p++) nxt[p] = mdl[p];
        if (!h) begin
            nxt[0] = mdl[WAYS-1];
            for (int p = 1; p < WAYS; p++) nxt[p] = mdl[p-1];
        end else if (m == 0 || m == 3) begin
            nxt[0] = mdl[hp];
            for (int p = 1; p <= hp; p++) nxt[p] = mdl[p-1];
        end else if (m == 2) begin
            for (int q = 0; q < WAYS; q++) begin
                np = q;
                for (int l = 0; l < IW; l++) begin
                    lowm = (1 << l) - 1;
                    if (((q & lowm) == (hp & lowm)) && (((hp >> l) & 1) == 1))
                        np = np ^ (1 << l);
                end
                nxt[np] = mdl[q];
            end
        end
        for (int p = 0; p < WAYS; p++) mdl[p] = nxt[p];
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    // One access: drive at the falling edge, check after the rising edge.
    task automatic step(input bit v, input bit h, input int w, input int m, input string tag);
        @(negedge clk);
        acc_valid = v;
        acc_hit   = h;
        acc_way   = IW'(w);
        acc_mode  = 2'(m);
        #2;
        if (v && !h) check_int("R3 victim", int'(victim_way), mdl[WAYS-1]);
        model_apply(v, h, w, m);
        @(posedge clk);
        #2;
        check_order(tag);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        apply_reset();
        check_order("R1 reset order");
        check_int("R1 reset victim", int'(victim_way), WAYS - 1);
    endtask

    task automatic t_hold();
        apply_reset();
        step(1, 0, 0, 0, "R3 scramble");
        step(1, 1, 2, 0, "R4 scramble");
        for (int k = 0; k < 8; k++) step(0, k[0], k % WAYS, k % 4, "R2 invalid hold");
        step(0, 0, 0, 2, "R2 invalid miss hold");
    endtask

    task automatic t_recency(input int m);
        apply_reset();
        step(1, 1, dut_pos(WAYS-1), m, m == 3 ? "R7 hit last" : "R4 hit last");
        step(1, 1, dut_pos(1), m, m == 3 ? "R7 hit mid" : "R4 hit mid");
        step(1, 1, dut_pos(0), m, m == 3 ? "R7 hit front" : "R4 hit front");
        step(1, 1, dut_pos(2), m, m == 3 ? "R7 hit pos2" : "R4 hit pos2");
    endtask

    task automatic t_fill();
        apply_reset();
        step(1, 0, 0, 1, "R3 fill miss");
        for (int k = 0; k < WAYS; k++) step(1, 1, dut_pos(k), 1, "R5 fill hit");
    endtask

    task automatic t_tree();
        apply_reset();
        for (int k = 0; k < WAYS; k++) step(1, 1, dut_pos(k), 2, "R6 tree hit");
        step(1, 0, 0, 2, "R3 tree miss");
        for (int k = WAYS - 1; k >= 0; k--) step(1, 1, dut_pos(k), 2, "R6 tree hit");
    endtask

    task automatic t_evict(input int m);
        int target;
        int alive;
        for (int j = 0; j < WAYS; j++) begin
            apply_reset();
            for (int k = 0; k < 6; k++) step(1, 1, int'($urandom_range(WAYS-1)), m, "R8 warm");
            target = dut_pos(j);
            for (int k = 1; k <= WAYS - j; k++) begin
                check_int("R8 victim before miss", int'(victim_way == IW'(target)),
                          (k == WAYS - j) ? 1 : 0);
                step(1, 0, 0, m, "R8 miss");
                alive = 0;
                for (int p = 1; p < WAYS; p++) if (dut_pos(p) == target) alive = 1;
                check_int("R8 still cached", alive, (k < WAYS - j) ? 1 : 0);
            end
        end
    endtask

    task automatic t_random(input int m, input int count);
        bit v;
        bit h;
        int mm;
        apply_reset();
        for (int k = 0; k < count; k++) begin
            v  = ($urandom_range(9) != 0);
            h  = ($urandom_range(2) != 0);
            mm = (m < 0) ? int'($urandom_range(3)) : m;
            step(v, h, int'($urandom_range(WAYS-1)), mm,
                 mm == 2 ? "R6 random" : (mm == 1 ? "R5 random" : "R4 random"));
        end
    endtask

    initial begin
        #(2 * HALF * 150000);
        n_fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        model_reset();
        t_reset();
        t_hold();
        t_recency(0);
        t_recency(3);
        t_fill();
        t_tree();
        for (int m = 0; m < 4; m++) t_evict(m);
        for (int m = 0; m < 4; m++) t_random(m, 400);
        t_random(-1, 600);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule